// File: doc/BRIEF.md
# Bus Turnaround Delay Scheduler

This block sits between a transaction request port and a static-memory bus sequencer. It holds off a new request for a number of idle clock cycles that depends on the transaction granted just before it. For each granted transaction it records whether it was synchronous or asynchronous, whether it was a read or a write, its bank number, and whether it used a multiplexed-address (or D) protocol rather than a plain asynchronous mode.

When a request is presented, a rule table compares the recorded history with the new request and picks one of three gaps. The gap can be zero, a fixed count of 1, 2 or 3 cycles, or the value of a 4-bit programmable turnaround field. The field is written through a simple register write port. While the gap counts down, `req_ready_o` stays low. A request is granted on a clock edge where `req_valid_i` and `req_ready_o` are both high. A granted request becomes the new history.

Top module: `turnaround_sched`

## Requirements
- R1: The turnaround field is 4 bits wide and resets to 15. A pair that uses the programmed gap, issued before any field write, waits 15 idle cycles.
- R2: Writing value N (0 to 15) with `cfg_we_i` makes every later pair that uses the programmed gap wait exactly N idle cycles.
- R3: The first request after reset is granted in the first cycle it is valid. With no request valid, `req_ready_o` is low.
- R4: An asynchronous write followed by an asynchronous write to the same bank waits 0 cycles when the previous write was not multiplexed. It waits the programmed gap when the previous write was multiplexed.
- R5: A non-multiplexed asynchronous write followed by a synchronous write to any bank waits exactly 1 cycle.
- R6: After a non-multiplexed asynchronous read, a read from a different bank waits 1 cycle. A read from the same bank waits 0 cycles, and a write waits 0 cycles.
- R7: After a multiplexed asynchronous read, every next access waits the programmed gap.
- R8: After a synchronous write, a synchronous write to the same bank waits 2 cycles. A synchronous write to a different bank waits 3 cycles, and any synchronous read waits 3 cycles.
- R9: After a synchronous write, any asynchronous access waits exactly 2 cycles.
- R10: After two consecutive synchronous reads, an access to a different bank waits 2 cycles. It waits 0 cycles when the bank is the same or when only one synchronous read preceded it.
- R11: After a non-multiplexed asynchronous write, a same-bank access that is not a synchronous write waits 0 cycles. A different-bank access that is not a synchronous write waits the programmed gap. Any access after a multiplexed asynchronous write, other than the R4 case, also waits the programmed gap.
- R12: Count the gap D from the first cycle a request is valid. `req_ready_o` is then low for exactly D cycles and high in the cycle after them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Write strobe for the turnaround field |
| cfg_turn_i | input | TURN_W | New turnaround field value |
| req_valid_i | input | 1 | Request present; held until granted |
| req_sync_i | input | 1 | 1 = synchronous access, 0 = asynchronous |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_mux_i | input | 1 | 1 = multiplexed-address or D protocol, 0 = plain asynchronous mode |
| req_bank_i | input | BANK_W | Target bank |
| req_ready_o | output | 1 | Request may be granted this cycle |

## Verification
The bench steps through every ordered pair of the eight access kinds (sync/async, read/write, multiplexed or not), each with a same-bank and a different-bank target. It repeats the sweep under three field values: 0, a middle value and 15. Because the field value changes between sweeps, a gap taken from the field can be told apart from a fixed count. The same-bank and different-bank targets separate the 2-cycle from the 3-cycle synchronous write case and the 0-cycle from the 1-cycle asynchronous read case. Running the pairs back to back produces runs of synchronous reads. Those runs show whether the two-read history is tracked, as opposed to a single previous read. The gap before the first field write checks the reset value.

// File: rtl/tat_pkg.sv
package tat_pkg;
  typedef struct packed {
    logic sync;
    logic write;
    logic mux;
  } kind_t;

  typedef enum logic [1:0] {
    SRC_ZERO  = 2'd0,
    SRC_FIXED = 2'd1,
    SRC_PROG  = 2'd2
  } src_e;

  localparam int unsigned FIX_ONE   = 1;
  localparam int unsigned FIX_TWO   = 2;
  localparam int unsigned FIX_THREE = 3;
endpackage

// File: rtl/tat_cfg.sv
module tat_cfg #(
  parameter int unsigned TURN_W   = 4,
  parameter int unsigned TURN_RST = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [TURN_W-1:0] wdata_i,
  output logic [TURN_W-1:0] turn_o
);
  logic [TURN_W-1:0] turn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   turn_q <= TURN_W'(TURN_RST);
    else if (we_i) turn_q <= wdata_i;
  end

  assign turn_o = turn_q;
endmodule

// File: rtl/tat_history.sv
module tat_history
  import tat_pkg::*;
#(
  parameter int unsigned BANK_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  kind_t             kind_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic              vld_o,
  output kind_t             kind_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              rd_run_o
);
  logic              vld_q;
  kind_t             kind_q;
  logic [BANK_W-1:0] bank_q;
  logic              run_q;
  logic              prev_srd, cur_srd;

  assign prev_srd = vld_q & kind_q.sync & ~kind_q.write;
  assign cur_srd  = kind_i.sync & ~kind_i.write;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      kind_q <= '0;
      bank_q <= '0;
      run_q  <= 1'b0;
    end else if (acc_i) begin
      vld_q  <= 1'b1;
      kind_q <= kind_i;
      bank_q <= bank_i;
      run_q  <= prev_srd & cur_srd;
    end
  end

  assign vld_o    = vld_q;
  assign kind_o   = kind_q;
  assign bank_o   = bank_q;
  assign rd_run_o = run_q;
endmodule

// File: rtl/tat_rules.sv
module tat_rules
  import tat_pkg::*;
#(
  parameter int unsigned BANK_W = 2,
  parameter int unsigned TURN_W = 4
) (
  input  logic              prev_vld_i,
  input  kind_t             prev_i,
  input  logic [BANK_W-1:0] prev_bank_i,
  input  logic              rd_run_i,
  input  kind_t             next_i,
  input  logic [BANK_W-1:0] next_bank_i,
  output src_e              src_o,
  output logic [TURN_W-1:0] fix_o
);
  logic same;
  assign same = (prev_bank_i == next_bank_i);

  always_comb begin
    src_o = SRC_ZERO;
    fix_o = '0;
    if (!prev_vld_i) begin
      src_o = SRC_ZERO;
    end else if (prev_i.sync && prev_i.write) begin
      // sync write: conflicting pairs resolve to the larger count
      src_o = SRC_FIXED;
      if (next_i.sync && next_i.write && same) fix_o = TURN_W'(FIX_TWO);
      else if (next_i.sync)                    fix_o = TURN_W'(FIX_THREE);
      else                                     fix_o = TURN_W'(FIX_TWO);
    end else if (!prev_i.sync && prev_i.write) begin
      if (prev_i.mux) begin
        src_o = SRC_PROG;
      end else if (next_i.sync && next_i.write) begin
        src_o = SRC_FIXED;
        fix_o = TURN_W'(FIX_ONE);
      end else if (same) begin
        src_o = SRC_ZERO;
      end else begin
        src_o = SRC_PROG;
      end
    end else if (!prev_i.sync) begin
      if (prev_i.mux) begin
        src_o = SRC_PROG;
      end else if (!next_i.write && !same) begin
        src_o = SRC_FIXED;
        fix_o = TURN_W'(FIX_ONE);
      end
    end else begin
      if (rd_run_i && !same) begin
        src_o = SRC_FIXED;
        fix_o = TURN_W'(FIX_TWO);
      end
    end
  end
endmodule

// File: rtl/tat_count.sv
module tat_count #(
  parameter int unsigned TURN_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [TURN_W-1:0] dly_i,
  output logic              ready_o
);
  typedef enum logic {ST_FREE, ST_WAIT} st_e;

  st_e               st_q;
  logic [TURN_W-1:0] cnt_q;

  always_comb begin
    ready_o = 1'b0;
    if (st_q == ST_FREE) ready_o = valid_i && (dly_i == '0);
    else                 ready_o = (cnt_q == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_FREE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        ST_FREE: if (valid_i && dly_i != '0) begin
          st_q  <= ST_WAIT;
          cnt_q <= dly_i - 1'b1;
        end
        default: if (cnt_q == '0) begin
          if (valid_i) st_q <= ST_FREE;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/turnaround_sched.sv
module turnaround_sched
  import tat_pkg::*;
#(
  parameter int unsigned BANK_W   = 2,
  parameter int unsigned TURN_W   = 4,
  parameter int unsigned TURN_RST = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [TURN_W-1:0] cfg_turn_i,
  input  logic              req_valid_i,
  input  logic              req_sync_i,
  input  logic              req_write_i,
  input  logic              req_mux_i,
  input  logic [BANK_W-1:0] req_bank_i,
  output logic              req_ready_o
);
  kind_t             next_kind, prev_kind;
  logic [BANK_W-1:0] prev_bank;
  logic              prev_vld, rd_run, acc;
  logic [TURN_W-1:0] turn_q, fix, dly;
  src_e              src;

  assign next_kind = '{sync: req_sync_i, write: req_write_i, mux: req_mux_i};
  assign acc       = req_valid_i & req_ready_o;

  tat_cfg #(.TURN_W(TURN_W), .TURN_RST(TURN_RST)) i_cfg (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .wdata_i(cfg_turn_i), .turn_o(turn_q)
  );

  tat_history #(.BANK_W(BANK_W)) i_hist (
    .clk_i, .rst_ni, .acc_i(acc), .kind_i(next_kind), .bank_i(req_bank_i),
    .vld_o(prev_vld), .kind_o(prev_kind), .bank_o(prev_bank), .rd_run_o(rd_run)
  );

  tat_rules #(.BANK_W(BANK_W), .TURN_W(TURN_W)) i_rules (
    .prev_vld_i(prev_vld), .prev_i(prev_kind), .prev_bank_i(prev_bank),
    .rd_run_i(rd_run), .next_i(next_kind), .next_bank_i(req_bank_i),
    .src_o(src), .fix_o(fix)
  );

  always_comb begin
    case (src)
      SRC_PROG:  dly = turn_q;
      SRC_FIXED: dly = fix;
      default:   dly = '0;
    endcase
  end

  tat_count #(.TURN_W(TURN_W)) i_count (
    .clk_i, .rst_ni, .valid_i(req_valid_i), .dly_i(dly), .ready_o(req_ready_o)
  );
endmodule

// File: rtl/tat_chk.sv
module tat_chk #(
  parameter int unsigned BANK_W   = 2,
  parameter int unsigned TURN_W   = 4,
  parameter int unsigned TURN_RST = 15
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic              req_valid_i,
  input logic              req_sync_i,
  input logic              req_write_i,
  input logic              req_mux_i,
  input logic [BANK_W-1:0] req_bank_i,
  input logic              req_ready_o,
  input logic [TURN_W-1:0] turn_q
);
  logic              seen_acc, cfg_seen, acc;
  logic [TURN_W:0]   stall;
  logic              p_sync, p_wr, p_mux;
  logic [BANK_W-1:0] p_bank;

  assign acc = req_valid_i & req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_acc <= 1'b0;
      cfg_seen <= 1'b0;
      stall    <= '0;
      p_sync   <= 1'b0;
      p_wr     <= 1'b0;
      p_mux    <= 1'b0;
      p_bank   <= '0;
    end else begin
      if (cfg_we_i) cfg_seen <= 1'b1;
      if (acc) begin
        seen_acc <= 1'b1;
        stall    <= '0;
        p_sync   <= req_sync_i;
        p_wr     <= req_write_i;
        p_mux    <= req_mux_i;
        p_bank   <= req_bank_i;
      end else if (req_valid_i) begin
        stall <= stall + 1'b1;
      end
    end
  end

  // R3
  first_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !seen_acc |-> req_ready_o);

  // R1
  turn_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_seen |-> turn_q == TURN_W'(TURN_RST));

  // R12
  stall_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall <= (TURN_W+1)'((1 << TURN_W) - 1));

  // R8
  swr_srd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && seen_acc && p_sync && p_wr && req_sync_i && !req_write_i |-> stall == 3);

  // R9
  swr_async_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && seen_acc && p_sync && p_wr && !req_sync_i |-> stall == 2);

  // R4
  awr_same_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && stall == 0 && seen_acc && !p_sync && p_wr && !p_mux &&
    !req_sync_i && req_write_i && req_bank_i == p_bank |-> req_ready_o);
endmodule

bind turnaround_sched tat_chk #(
  .BANK_W(BANK_W), .TURN_W(TURN_W), .TURN_RST(TURN_RST)
) i_tat_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i),
  .req_valid_i(req_valid_i), .req_sync_i(req_sync_i),
  .req_write_i(req_write_i), .req_mux_i(req_mux_i),
  .req_bank_i(req_bank_i), .req_ready_o(req_ready_o), .turn_q(turn_q)
);

// File: tb/test_turnaround_sched.sv
module test_turnaround_sched;
  localparam int CLK_PERIOD = 10;
  localparam int BANK_W = 2;
  localparam int TURN_W = 4;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              cfg_we_i = 1'b0;
  logic [TURN_W-1:0] cfg_turn_i = '0;
  logic              req_valid_i = 1'b0;
  logic              req_sync_i = 1'b0;
  logic              req_write_i = 1'b0;
  logic              req_mux_i = 1'b0;
  logic [BANK_W-1:0] req_bank_i = '0;
  logic              req_ready_o;

  int n_chk = 0;
  int n_fail = 0;

  bit h_vld = 0, h_s = 0, h_w = 0, h_m = 0, h_run = 0;
  int h_bank = 0;
  int cfg = 15;

  turnaround_sched #(.BANK_W(BANK_W), .TURN_W(TURN_W)) i_turnaround_sched (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int model(input bit ns, input bit nw, input int nb, output string tag);
    bit same;
    if (!h_vld) begin tag = "R3"; return 0; end
    same = (nb == h_bank);
    if (h_s && h_w) begin
      if (ns) begin tag = "R8"; return (nw && same) ? 2 : 3; end
      tag = "R9"; return 2;
    end
    if (!h_s && h_w) begin
      if (h_m) begin tag = (!ns && nw && same) ? "R4 R2" : "R11 R2"; return cfg; end
      if (ns && nw) begin tag = "R5"; return 1; end
      if (same) begin tag = (!ns && nw) ? "R4" : "R11"; return 0; end
      tag = "R11 R2"; return cfg;
    end
    if (!h_s) begin
      if (h_m) begin tag = "R7 R2"; return cfg; end
      tag = "R6"; return (!nw && !same) ? 1 : 0;
    end
    tag = "R10"; return (h_run && !same) ? 2 : 0;
  endfunction

  // R12: stall = cycles with ready low from first valid cycle
  task automatic issue(input bit ns, input bit nw, input bit nm, input int nb);
    int stall = 0;
    int exp;
    string tag;
    exp = model(ns, nw, nb, tag);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_sync_i = ns; req_write_i = nw;
    req_mux_i = nm; req_bank_i = BANK_W'(nb);
    #1;
    while (!req_ready_o && stall < 40) begin
      @(negedge clk_i);
      stall++;
      #1;
    end
    check({tag, " R12"}, stall, exp);
    h_run = h_vld && h_s && !h_w && ns && !nw;
    h_vld = 1; h_s = ns; h_w = nw; h_m = nm; h_bank = nb;
    @(posedge clk_i);
  endtask

  task automatic write_cfg(input int v);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    cfg_we_i = 1'b1; cfg_turn_i = TURN_W'(v);
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    cfg = v;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cfgs[3];
    cfgs[0] = 0; cfgs[1] = 6; cfgs[2] = 15;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R3 idle ready", int'(req_ready_o), 0);
    issue(0, 1, 1, 0);            // R3 first request, no gap
    issue(0, 1, 1, 0);            // R1 reset field 15 via R4 mux case
    issue(0, 0, 1, 2);            // R1 again, R11 mux
    for (int c = 0; c < 3; c++) begin
      write_cfg(cfgs[c]);         // R2
      for (int p = 0; p < 8; p++)
        for (int n = 0; n < 8; n++)
          for (int r = 0; r < 2; r++) begin
            int pb, nb;
            pb = (p + n) % 4;
            nb = r ? pb : (pb ^ 1);
            issue(p[2], p[1], p[0], pb);
            issue(n[2], n[1], n[0], nb);
          end
    end
    // R10: explicit sync read run then bank change
    issue(1, 0, 0, 0);
    issue(1, 0, 0, 0);
    issue(1, 0, 0, 3);
    issue(1, 0, 0, 3);
    issue(0, 0, 0, 3);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    #1;
    check("R12 ready low when idle", int'(req_ready_o), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule